// File: doc/BRIEF.md
# Parallel EEPROM Page Programming Sequencer

This block runs on the host side and writes one page of EEPROM data into a target device over a parallel programming interface. A single start request carries the page's upper address byte. After that the block pulls pairs of a lower address byte and a data byte from a valid/ready stream, one pair for each location in the page. It drives the target's 8-bit data bus, a two-bit load-type select, a byte-select line, a load clock, a page-buffer latch strobe and an active-low write strobe. It also watches the target's ready/busy line.

Each page runs in a fixed order:
1. An EEPROM-write command load.
2. One upper-address load.
3. For every byte: a lower-address load, a data load and a latch pulse.
4. A single write strobe that commits the buffered page.
5. A wait until the target reports ready again.

The block then gives a one-cycle completion pulse. If ready never returns within a set number of cycles, it gives a one-cycle error pulse instead. In both cases it goes back to idle and can take the next page.

Top module: `eeprom_page_seq`

## Requirements
- R1: While reset is held and whenever the block is idle, the target pins are parked: bus 0x00, load select 2'b00, load clock low, latch low, write strobe high, byte select high. In the same conditions `startReady` is 1 and `byteReady`, `pageFull`, `done` and `err` are 0.
- R2: A start is taken only on a clock edge where `startReady` is 1, and `pageHi` is captured on that edge. A `startReq` seen while a page is in progress has no effect on the pins.
- R3: Every load is a window of PULSE_CYC+2 cycles with the byte and select held constant for the whole window. The load clock is high for the middle PULSE_CYC cycles, which leaves one stable cycle before and one after the pulse. The first load of a page drives byte 0x11 with select 2'b10 (command).
- R4: The second load drives the captured upper address with select 2'b00 (address).
- R5: `byteReady` is 1 only while the block waits for the next pair. An accepted pair is captured at the handshake edge. The block then loads the lower address with select 2'b00, followed by the data byte with select 2'b01.
- R6: After each data load comes a latch window of PULSE_CYC+2 cycles: bus 0x00, select 2'b00, latch strobe high for the middle PULSE_CYC cycles.
- R7: The address/data/latch group runs exactly PAGE_BYTES times. `pageFull` is 1 from the end of the last latch window until the block returns to idle.
- R8: The commit is one write-strobe window of PULSE_CYC+2 cycles, with the write strobe low for the middle PULSE_CYC cycles. It happens only after PAGE_BYTES latches. Byte select is low from the first command cycle until the block returns to idle.
- R9: The block synchronises the ready line through two flops. It finishes the wait in the first wait cycle in which the synchronised value is 1, and `done` is 1 for exactly the following cycle.
- R10: If the synchronised ready value stays 0 for BUSY_LIMIT wait cycles, `err` is 1 for exactly the following cycle. The block then returns to idle without a `done` pulse.
- R11: At most one of load clock high, latch high and write strobe low holds in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to program one page |
| pageHi | input | 8 | Upper address byte of the page, taken with the start |
| startReady | output | 1 | Idle and able to take a start |
| byteValid | input | 1 | Address/data pair is offered |
| byteAddr | input | 8 | Lower address byte of the offered pair |
| byteData | input | 8 | Data byte of the offered pair |
| byteReady | output | 1 | Waiting for the next pair |
| tgtData | output | 8 | Target data bus |
| tgtLoadSel | output | 2 | Load type: 00 address, 01 data, 10 command |
| tgtBs1 | output | 1 | Target byte select, low during a page |
| tgtWrN | output | 1 | Active-low commit strobe |
| tgtLatch | output | 1 | Page-buffer latch strobe |
| tgtClk | output | 1 | Load clock pulse |
| tgtRdy | input | 1 | Target ready (1) / busy (0) |
| pageFull | output | 1 | Page buffer filled, commit or wait under way |
| done | output | 1 | One-cycle pulse: page programmed |
| err | output | 1 | One-cycle pulse: ready wait timed out |

## Verification
All pins follow directly from the sequencer's state and phase counter. If the phase count is wrong, a strobe edge moves by a cycle in that same cycle, or the setup or hold cycle around a strobe disappears. If the byte count is wrong, the write strobe shows up one latch window early or late. If the captured bytes are wrong, the wrong value appears on the bus during its load window. The bench runs a behavioural model alongside the design and compares every output on every cycle, so any of these faults is reported in the first cycle where a pin differs. Only the wait counter is less direct: a fault there shows up as an `err` or `done` pulse in the wrong cycle.

// File: rtl/eps_pkg.sv
package eps_pkg;

  localparam logic [7:0] CMD_EE_WRITE = 8'h11;
  localparam logic [1:0] LOAD_ADDR    = 2'b00;
  localparam logic [1:0] LOAD_DATA    = 2'b01;
  localparam logic [1:0] LOAD_CMD     = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_HI, S_WAITB, S_LO, S_DAT, S_LAT, S_WR, S_BUSY
  } seqStateT;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_CMD, SRC_HI, SRC_LO, SRC_DAT
  } busSrcT;

  typedef struct packed {
    busSrcT     src;
    logic [1:0] loadSel;
    logic       xtal;
    logic       latch;
    logic       wr;
    logic       active;
    logic       capHi;
    logic       capByte;
  } strobeT;

endpackage

// File: rtl/eps_ctrl.sv
module eps_ctrl
  import eps_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int PULSE_CYC  = 2,
  parameter int BUSY_LIMIT = 50000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   byteValid,
  input  logic   rdySync,
  output strobeT strb,
  output logic   startReady,
  output logic   byteReady,
  output logic   pageFull,
  output logic   done,
  output logic   err
);

  localparam int PH_W   = $clog2(PULSE_CYC + 2);
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int BUSY_W = $clog2(BUSY_LIMIT + 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PAGE_BYTES - 1);
  localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(BUSY_LIMIT - 1);

  seqStateT          state, nextOp;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  byteCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              doneQ, errQ;
  logic              pulseOn;

  assign pulseOn = (phase != '0) && (phase != PH_LAST);

  always_comb begin
    unique case (state)
      S_CMD:   nextOp = S_HI;
      S_HI:    nextOp = S_WAITB;
      S_LO:    nextOp = S_DAT;
      S_DAT:   nextOp = S_LAT;
      S_LAT:   nextOp = (byteCnt == CNT_LAST) ? S_WR : S_WAITB;
      S_WR:    nextOp = S_BUSY;
      default: nextOp = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      byteCnt <= '0;
      busyCnt <= '0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      unique case (state)
        S_IDLE: if (startReq) begin
          state   <= S_CMD;
          phase   <= '0;
          byteCnt <= '0;
        end
        S_WAITB: if (byteValid) begin
          state <= S_LO;
          phase <= '0;
        end
        S_BUSY: begin
          if (rdySync) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else if (busyCnt == BUSY_LAST) begin
            state <= S_IDLE;
            errQ  <= 1'b1;
          end else begin
            busyCnt <= busyCnt + 1'b1;
          end
        end
        default: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            state <= nextOp;
            if (state == S_LAT) byteCnt <= byteCnt + 1'b1;
            if (state == S_WR)  busyCnt <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.src     = SRC_NONE;
    strb.loadSel = LOAD_ADDR;
    strb.active  = (state != S_IDLE);
    strb.capHi   = (state == S_IDLE) && startReq;
    strb.capByte = (state == S_WAITB) && byteValid;
    unique case (state)
      S_CMD: begin strb.src = SRC_CMD; strb.loadSel = LOAD_CMD;  strb.xtal = pulseOn; end
      S_HI:  begin strb.src = SRC_HI;  strb.loadSel = LOAD_ADDR; strb.xtal = pulseOn; end
      S_LO:  begin strb.src = SRC_LO;  strb.loadSel = LOAD_ADDR; strb.xtal = pulseOn; end
      S_DAT: begin strb.src = SRC_DAT; strb.loadSel = LOAD_DATA; strb.xtal = pulseOn; end
      S_LAT: strb.latch = pulseOn;
      S_WR:  strb.wr    = pulseOn;
      default: ;
    endcase
  end

  assign startReady = (state == S_IDLE);
  assign byteReady  = (state == S_WAITB);
  assign pageFull   = (state == S_WR) || (state == S_BUSY);
  assign done       = doneQ;
  assign err        = errQ;

  // R2: a command window only opens straight from idle
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && phase == '0) |-> $past(state == S_IDLE));

  // R7: never more latches than the page holds
  p_byte_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(PAGE_BYTES));

  // R8: commit only with a full buffer
  p_wr_after_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WR) |-> (byteCnt == CNT_W'(PAGE_BYTES)));

  // R9: completion pulse follows a wait cycle and never coincides with an error
  p_done_from_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(state == S_BUSY) && !err));

  // R10: error only after the full wait window
  p_err_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> ($past(busyCnt) == BUSY_LAST && $past(state == S_BUSY)));

endmodule

// File: rtl/eps_datapath.sv
module eps_datapath
  import eps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strb,
  input  logic [7:0] pageHi,
  input  logic [7:0] byteAddr,
  input  logic [7:0] byteData,
  input  logic       tgtRdy,
  output logic       rdySync,
  output logic [7:0] tgtData,
  output logic [1:0] tgtLoadSel,
  output logic       tgtBs1,
  output logic       tgtWrN,
  output logic       tgtLatch,
  output logic       tgtClk
);

  logic [7:0] hiQ, loQ, datQ;
  logic       rdyMeta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ     <= '0;
      loQ     <= '0;
      datQ    <= '0;
      rdyMeta <= 1'b0;
      rdySync <= 1'b0;
    end else begin
      rdyMeta <= tgtRdy;
      rdySync <= rdyMeta;
      if (strb.capHi) hiQ <= pageHi;
      if (strb.capByte) begin
        loQ  <= byteAddr;
        datQ <= byteData;
      end
    end
  end

  always_comb begin
    unique case (strb.src)
      SRC_CMD: tgtData = CMD_EE_WRITE;
      SRC_HI:  tgtData = hiQ;
      SRC_LO:  tgtData = loQ;
      SRC_DAT: tgtData = datQ;
      default: tgtData = 8'h00;
    endcase
  end

  assign tgtLoadSel = strb.loadSel;
  assign tgtClk     = strb.xtal;
  assign tgtLatch   = strb.latch;
  assign tgtWrN     = ~strb.wr;
  assign tgtBs1     = ~strb.active;

  // R11: strobes are mutually exclusive
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tgtClk, tgtLatch, ~tgtWrN}));

  // R3: bus and select already stable in the cycle before the load clock rises
  p_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtClk) |-> ($stable(tgtData) && $stable(tgtLoadSel)));

  // R3: bus and select held through the cycle after the load clock falls
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtClk) |-> ($stable(tgtData) && $stable(tgtLoadSel)));

endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
  import eps_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int PULSE_CYC  = 2,
  parameter int BUSY_LIMIT = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] pageHi,
  output logic       startReady,
  input  logic       byteValid,
  input  logic [7:0] byteAddr,
  input  logic [7:0] byteData,
  output logic       byteReady,
  output logic [7:0] tgtData,
  output logic [1:0] tgtLoadSel,
  output logic       tgtBs1,
  output logic       tgtWrN,
  output logic       tgtLatch,
  output logic       tgtClk,
  input  logic       tgtRdy,
  output logic       pageFull,
  output logic       done,
  output logic       err
);

  strobeT strb;
  logic   rdySync;

  eps_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .PULSE_CYC (PULSE_CYC),
    .BUSY_LIMIT(BUSY_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .byteValid (byteValid),
    .rdySync   (rdySync),
    .strb      (strb),
    .startReady(startReady),
    .byteReady (byteReady),
    .pageFull  (pageFull),
    .done      (done),
    .err       (err)
  );

  eps_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pageHi    (pageHi),
    .byteAddr  (byteAddr),
    .byteData  (byteData),
    .tgtRdy    (tgtRdy),
    .rdySync   (rdySync),
    .tgtData   (tgtData),
    .tgtLoadSel(tgtLoadSel),
    .tgtBs1    (tgtBs1),
    .tgtWrN    (tgtWrN),
    .tgtLatch  (tgtLatch),
    .tgtClk    (tgtClk)
  );

endmodule

// File: tb/eeprom_page_seq_tb.sv
`timescale 1ns/1ps
module eeprom_page_seq_tb;

  localparam int PB = 4;
  localparam int PW = 2;
  localparam int BL = 40;

  logic       clk = 1'b0;
  logic       rstN, startReq, byteValid, tgtRdy;
  logic [7:0] pageHi, byteAddr, byteData;
  logic       startReady, byteReady, tgtBs1, tgtWrN, tgtLatch, tgtClk;
  logic       pageFull, done, err;
  logic [7:0] tgtData;
  logic [1:0] tgtLoadSel;

  always #2 clk = ~clk;

  eeprom_page_seq #(.PAGE_BYTES(PB), .PULSE_CYC(PW), .BUSY_LIMIT(BL)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pageHi(pageHi),
    .startReady(startReady), .byteValid(byteValid), .byteAddr(byteAddr),
    .byteData(byteData), .byteReady(byteReady), .tgtData(tgtData),
    .tgtLoadSel(tgtLoadSel), .tgtBs1(tgtBs1), .tgtWrN(tgtWrN),
    .tgtLatch(tgtLatch), .tgtClk(tgtClk), .tgtRdy(tgtRdy),
    .pageFull(pageFull), .done(done), .err(err)
  );

  int  nCmp = 0, nBad = 0;
  int  doneCnt = 0, errCnt = 0;
  bit  modelOn = 0, ended = 0;

  // expected outputs
  logic [7:0] eData;
  logic [1:0] eSel;
  logic eXtal, eLatch, eWrN, eBs1, eStartRdy, eByteRdy, eFull, eDone, eErr;

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic rS1 = 1'b0, rS2 = 1'b0;
  always @(posedge clk) begin rS1 <= tgtRdy; rS2 <= rS1; end

  task automatic setIdle();
    eData = 8'h00; eSel = 2'b00; eXtal = 0; eLatch = 0; eWrN = 1;
    eBs1 = 1; eStartRdy = 1; eByteRdy = 0; eFull = 0; eDone = 0; eErr = 0;
  endtask

  // kind 0: load clock, 1: latch, 2: commit
  task automatic opWindow(input logic [7:0] b, input logic [1:0] s, input int kind);
    for (int i = 0; i < PW + 2; i++) begin
      eData  = b;
      eSel   = s;
      eXtal  = (kind == 0) && (i >= 1) && (i <= PW);
      eLatch = (kind == 1) && (i >= 1) && (i <= PW);
      eWrN   = !((kind == 2) && (i >= 1) && (i <= PW));
      @(posedge clk); #1;
    end
  endtask

  task automatic runPage(input logic [7:0] hi);
    logic [7:0] a, d;
    bit got;
    int cnt;
    #1;
    setIdle();
    eBs1 = 0; eStartRdy = 0;
    opWindow(8'h11, 2'b10, 0);
    opWindow(hi, 2'b00, 0);
    for (int k = 0; k < PB; k++) begin
      eByteRdy = 1; eData = 8'h00; eSel = 2'b00;
      got = 0;
      while (!got) begin
        @(posedge clk);
        got = byteValid;
        a = byteAddr; d = byteData;
        #1;
      end
      eByteRdy = 0;
      opWindow(a, 2'b00, 0);
      opWindow(d, 2'b01, 0);
      opWindow(8'h00, 2'b00, 1);
    end
    eFull = 1;
    opWindow(8'h00, 2'b00, 2);
    cnt = 0;
    forever begin
      @(posedge clk);
      if (rS2) begin #1; setIdle(); eDone = 1; break; end
      else if (cnt == BL - 1) begin #1; setIdle(); eErr = 1; break; end
      cnt++;
      #1;
    end
  endtask

  initial begin
    setIdle();
    wait (modelOn);
    forever begin
      @(posedge clk);
      if (startReq) runPage(pageHi);
      else begin #1; eDone = 0; eErr = 0; end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (modelOn && !ended) begin
      chk("R5 tgtData",    tgtData,    eData);
      chk("R4 tgtLoadSel", tgtLoadSel, eSel);
      chk("R3 tgtClk",     tgtClk,     eXtal);
      chk("R6 tgtLatch",   tgtLatch,   eLatch);
      chk("R8 tgtWrN",     tgtWrN,     eWrN);
      chk("R8 tgtBs1",     tgtBs1,     eBs1);
      chk("R2 startReady", startReady, eStartRdy);
      chk("R5 byteReady",  byteReady,  eByteRdy);
      chk("R7 pageFull",   pageFull,   eFull);
      chk("R9 done",       done,       eDone);
      chk("R10 err",       err,        eErr);
      chk("R11 strobes",   ($countones({tgtClk, tgtLatch, ~tgtWrN}) <= 1), 1);
      if (done) doneCnt++;
      if (err)  errCnt++;
    end
  end

  // ---------------- target model ----------------
  int  busyLen = 10;
  int  busyRem = 0;
  bit  tgtBusy = 0;
  always @(negedge clk) begin
    if (!tgtWrN && !tgtBusy) begin
      tgtBusy = 1; tgtRdy = 0; busyRem = busyLen;
    end else if (tgtBusy) begin
      if (busyRem == 0) begin tgtRdy = 1; tgtBusy = 0; end
      else busyRem--;
    end
  end

  // ---------------- stimulus ----------------
  task automatic startPage(input logic [7:0] hi);
    @(negedge clk);
    while (!startReady) @(negedge clk);
    startReq = 1; pageHi = hi;
    @(negedge clk);
    startReq = 0; pageHi = ~hi;   // later changes must not matter (R2)
  endtask

  task automatic sendByte(input logic [7:0] a, input logic [7:0] d, input int gap);
    repeat (gap) @(negedge clk);
    byteValid = 1; byteAddr = a; byteData = d;
    while (!byteReady) @(negedge clk);
    @(negedge clk);
    byteValid = 0; byteAddr = ~a; byteData = ~d;  // captured copy must be used (R5)
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!startReady || !tgtRdy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    rstN = 0; startReq = 0; pageHi = 0; byteValid = 0;
    byteAddr = 0; byteData = 0; tgtRdy = 1;
    repeat (3) @(negedge clk);
    // R1: parked pins under reset
    chk("R1 reset tgtData", tgtData, 0);
    chk("R1 reset tgtLoadSel", tgtLoadSel, 0);
    chk("R1 reset strobes", {tgtClk, tgtLatch, tgtWrN, tgtBs1}, 4'b0011);
    chk("R1 reset readys", {startReady, byteReady}, 2'b10);
    chk("R1 reset flags", {pageFull, done, err}, 3'b000);
    rstN = 1;
    modelOn = 1;
    repeat (4) @(negedge clk);

    // page 1: back-to-back bytes, short busy
    busyLen = 10;
    startPage(8'h3A);
    for (int k = 0; k < PB; k++) sendByte(8'h10 + 8'(k), 8'hA0 + 8'(k), 0);
    waitIdle();

    // page 2: gaps, stray start mid-page (ignored), then start held into the done cycle
    busyLen = 6;
    startPage(8'h5C);
    sendByte(8'h00, 8'hFF, 3);
    @(negedge clk); startReq = 1; pageHi = 8'h99;
    repeat (2) @(negedge clk); startReq = 0;
    sendByte(8'h01, 8'h00, 5);
    sendByte(8'h02, 8'h55, 1);
    sendByte(8'h03, 8'hAA, 0);
    startReq = 1; pageHi = 8'hC5;
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    startReq = 0;
    // page 3 already running (started on the done cycle)
    for (int k = 0; k < PB; k++) sendByte(8'hF0 + 8'(k), 8'h3C ^ 8'(k), k);
    waitIdle();

    // page 4: target stays busy beyond the limit
    busyLen = 2 * BL;
    startPage(8'hE7);
    for (int k = 0; k < PB; k++) sendByte(8'(k), 8'(k * 17), 0);
    waitIdle();

    chk("R9 done pulses", doneCnt, 3);
    chk("R10 err pulses", errCnt, 1);
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule